// File: doc/BRIEF.md
# Page Walk Result Accumulator

This block sits behind a page-table walker and folds the entries of one translation walk into a single record for a TLB fill port. A walk begins with a start pulse that carries the linear page number and the mode bits for the walk. Entries then arrive one per valid beat, from the root level down. Permissions are merged across all levels: write and user rights are ANDed, and execute-disable is ORed. Dirty state, memory type and the protection key come from the final entry only.

Nothing is cached for a walk that meets a non-present entry or a reserved bit, and such a walk reports a fault code instead. An entry whose accessed bit is clear raises a write-back request. The fill is held back until every such request has been acknowledged. A large page can be issued as it is, aligned to its own size, or splintered into a 4 KB-granular record. A splintered record takes the low frame bits from the linear address and still carries the large page's size code.

Top module: `pwa_top`

## Requirements
- R1: The fill's write permission is the AND of entry bit 1 over every entry of the walk.
- R2: The fill's user permission is the AND of entry bit 2 over every entry of the walk.
- R3: The fill's no-execute bit is the OR of entry bit 63 over the walk when nx_en_i was 1 at start, and 0 otherwise.
- R4: The fill's protection key is bits 62:59 of the final entry when both four_lvl_i and pk_en_i were 1 at start, and 0 otherwise.
- R5: Dirty (bit 6) and memory type (bits 4:3) come only from the final entry. The final entry is a beat with ent_last_i set, the beat at the bottom level (beat LEVELS-1), or a beat one or two levels above the bottom whose bit 7 is 1.
- R6: An entry with bit 0 clear gives fault code 2'b01. An entry with any bit in 51:PA_W set gives fault code 2'b10. Not-present wins when both hold. A faulting walk never produces a fill, and 2'b00 means no fault.
- R7: An entry with bit 5 clear sets a pending write-back request for its level (beat index). The lowest pending level is presented on ad_lvl_o while ad_req_o is high, and ad_ack_i retires it. The fill waits until no request is pending.
- R8: A large final entry with splintering enabled yields a frame number whose upper bits come from the entry and whose low 9 bits (2 MB) or 18 bits (1 GB) come from the linear page number. The record carries the full linear page number.
- R9: After a fault, the fault code holds and further beats are ignored until the next start.
- R10: A start pulse clears all accumulated state, fault and pending requests of the previous walk.
- R11: The size code is 0 for 4 KB, 1 for 2 MB and 2 for 1 GB. Without splintering, the page and frame numbers of a large page are aligned, with their low 9 or 18 bits zero.
- R12: fill_valid_o is a one-cycle pulse. It comes in the cycle after the clock edge that takes the final entry, or after the edge that takes the last needed acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begins a new walk and latches the mode bits |
| lin_vpn_i | input | LA_W-12 | Linear page number of the access |
| nx_en_i | input | 1 | No-execute tracking enable |
| pk_en_i | input | 1 | Protection-key enable |
| four_lvl_i | input | 1 | Four-level paging active |
| splinter_en_i | input | 1 | Issue large pages as 4 KB-granular records |
| ent_valid_i | input | 1 | Entry beat valid |
| ent_data_i | input | 64 | Paging-structure entry |
| ent_last_i | input | 1 | Walker marks this beat as the last level |
| ad_ack_i | input | 1 | Acknowledge for the presented write-back request |
| fill_valid_o | output | 1 | Fill record valid pulse |
| fill_vpn_o | output | LA_W-12 | Page number of the record |
| fill_pfn_o | output | PA_W-12 | Frame number of the record |
| fill_write_o | output | 1 | Merged write permission |
| fill_user_o | output | 1 | Merged user permission |
| fill_nx_o | output | 1 | Merged no-execute |
| fill_pkey_o | output | 4 | Protection key |
| fill_dirty_o | output | 1 | Dirty flag of the final entry |
| fill_mtype_o | output | 2 | Memory-type bits of the final entry |
| fill_size_o | output | 2 | Page-size code |
| fault_o | output | 2 | Fault code |
| ad_req_o | output | 1 | Accessed-flag write-back request |
| ad_lvl_o | output | LVL_W | Level of the presented request |

## Verification
Every result is due one clock edge after its cause. A fault code, a pending request and a fill that needs no acknowledge all appear right after the edge that takes the entry. A held-back fill appears right after the edge that takes its last acknowledge. The bench drives on the falling edge and reads results at the next falling edge, so each check lands in the cycle its result is due. It also confirms that the fill pulse is gone one cycle later.

// File: rtl/pwa_pkg.sv
package pwa_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_WALK, ST_WAIT, ST_END} pwa_state_e;

  localparam logic [1:0] FLT_NONE = 2'b00;
  localparam logic [1:0] FLT_NP   = 2'b01;
  localparam logic [1:0] FLT_RSV  = 2'b10;

  localparam int B_PRES = 0;
  localparam int B_WR   = 1;
  localparam int B_USR  = 2;
  localparam int B_MT   = 3;
  localparam int B_ACC  = 5;
  localparam int B_DRT  = 6;
  localparam int B_BIG  = 7;
  localparam int B_PK   = 59;
  localparam int B_NX   = 63;
  localparam int PHYS_TOP = 52;

  function automatic logic [1:0] classify(input logic [63:0] ent, input logic [63:0] rsv_mask);
    if (!ent[B_PRES]) return FLT_NP;
    if ((ent & rsv_mask) != 64'd0) return FLT_RSV;
    return FLT_NONE;
  endfunction
endpackage

// File: rtl/pwa_perm_merge.sv
module pwa_perm_merge (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic take_i,
  input  logic wr_i,
  input  logic usr_i,
  input  logic nx_i,
  input  logic nx_en_i,
  output logic wr_o,
  output logic usr_o,
  output logic nx_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_o <= 1'b1; usr_o <= 1'b1; nx_o <= 1'b0;
    end else if (clear_i) begin
      wr_o <= 1'b1; usr_o <= 1'b1; nx_o <= 1'b0;
    end else if (take_i) begin
      wr_o  <= wr_o & wr_i;
      usr_o <= usr_o & usr_i;
      nx_o  <= nx_o | (nx_i & nx_en_i);
    end
  end

  assert_write_sticky_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_o && !clear_i) |=> !wr_o);
  assert_user_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!usr_o && !clear_i) |=> !usr_o);
  assert_nx_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!nx_en_i && !nx_o && !clear_i) |=> !nx_o);
endmodule

// File: rtl/pwa_ack_track.sv
module pwa_ack_track #(
  parameter int LEVELS = 4,
  localparam int LVL_W = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             set_i,
  input  logic [LVL_W-1:0] set_idx_i,
  input  logic             ack_i,
  output logic             req_o,
  output logic [LVL_W-1:0] req_idx_o,
  output logic [LEVELS-1:0] pend_nxt_o
);
  logic [LEVELS-1:0] pend_q, lowest, drop, add;

  assign lowest = pend_q & (~pend_q + LEVELS'(1));
  assign req_o  = |pend_q;
  assign drop   = (ack_i && req_o) ? lowest : '0;
  assign add    = set_i ? (LEVELS'(1) << set_idx_i) : '0;
  assign pend_nxt_o = clear_i ? '0 : ((pend_q & ~drop) | add);

  always_comb begin
    req_idx_o = '0;
    for (int i = LEVELS - 1; i >= 0; i--)
      if (pend_q[i]) req_idx_o = LVL_W'(i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_nxt_o;
  end

  assert_req_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && !ack_i && !clear_i) |=> req_o);
  assert_one_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(drop));
endmodule

// File: rtl/pwa_top.sv
module pwa_top #(
  parameter int LA_W   = 48,
  parameter int PA_W   = 40,
  parameter int LEVELS = 4,
  localparam int VPN_W = LA_W - 12,
  localparam int PFN_W = PA_W - 12,
  localparam int LVL_W = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [VPN_W-1:0] lin_vpn_i,
  input  logic             nx_en_i,
  input  logic             pk_en_i,
  input  logic             four_lvl_i,
  input  logic             splinter_en_i,
  input  logic             ent_valid_i,
  input  logic [63:0]      ent_data_i,
  input  logic             ent_last_i,
  input  logic             ad_ack_i,
  output logic             fill_valid_o,
  output logic [VPN_W-1:0] fill_vpn_o,
  output logic [PFN_W-1:0] fill_pfn_o,
  output logic             fill_write_o,
  output logic             fill_user_o,
  output logic             fill_nx_o,
  output logic [3:0]       fill_pkey_o,
  output logic             fill_dirty_o,
  output logic [1:0]       fill_mtype_o,
  output logic [1:0]       fill_size_o,
  output logic [1:0]       fault_o,
  output logic             ad_req_o,
  output logic [LVL_W-1:0] ad_lvl_o
);
  import pwa_pkg::*;

  localparam logic [63:0] RSV_MASK =
    ((64'd1 << PHYS_TOP) - 64'd1) & ~((64'd1 << PA_W) - 64'd1);

  function automatic logic [PFN_W-1:0] build_pfn(input logic [PFN_W-1:0] raw,
      input logic [VPN_W-1:0] vpn, input logic [1:0] sz, input logic spl);
    logic [PFN_W-1:0] lowm;
    lowm = (PFN_W'(1) << (9 * sz)) - PFN_W'(1);
    return spl ? ((raw & ~lowm) | (PFN_W'(vpn) & lowm)) : (raw & ~lowm);
  endfunction

  function automatic logic [VPN_W-1:0] build_vpn(input logic [VPN_W-1:0] vpn,
      input logic [1:0] sz, input logic spl);
    logic [VPN_W-1:0] lowm;
    lowm = (VPN_W'(1) << (9 * sz)) - VPN_W'(1);
    return spl ? vpn : (vpn & ~lowm);
  endfunction

  pwa_state_e       state_q;
  logic [LVL_W-1:0] beat_q, steps;
  logic [VPN_W-1:0] vpn_q;
  logic             nx_q, pk_q, four_q, spl_q;
  logic [PFN_W-1:0] fin_pfn_q;
  logic [3:0]       fin_pk_q;
  logic             fin_d_q;
  logic [1:0]       fin_mt_q, fin_sz_q;

  // named internal events
  logic             take, beat_bad, beat_ok, big_here, is_final, clear_trk;
  logic [1:0]       beat_flt, size_now;
  logic [LEVELS-1:0] pend_nxt;

  assign take     = (state_q == ST_WALK) && ent_valid_i && !start_i;
  assign beat_flt = classify(ent_data_i, RSV_MASK);
  assign beat_bad = take && (beat_flt != FLT_NONE);
  assign beat_ok  = take && (beat_flt == FLT_NONE);
  assign steps    = LVL_W'(LEVELS - 1) - beat_q;
  assign big_here = ent_data_i[B_BIG] && (steps == LVL_W'(1) || steps == LVL_W'(2));
  assign is_final = ent_last_i || (steps == '0) || big_here;
  assign size_now = big_here ? steps[1:0] : 2'd0;
  assign clear_trk = start_i || beat_bad;

  pwa_perm_merge u_perm (
    .clk(clk), .rst_n(rst_n), .clear_i(start_i), .take_i(beat_ok),
    .wr_i(ent_data_i[B_WR]), .usr_i(ent_data_i[B_USR]), .nx_i(ent_data_i[B_NX]),
    .nx_en_i(nx_q), .wr_o(fill_write_o), .usr_o(fill_user_o), .nx_o(fill_nx_o)
  );

  pwa_ack_track #(.LEVELS(LEVELS)) u_trk (
    .clk(clk), .rst_n(rst_n), .clear_i(clear_trk),
    .set_i(beat_ok && !ent_data_i[B_ACC]), .set_idx_i(beat_q), .ack_i(ad_ack_i),
    .req_o(ad_req_o), .req_idx_o(ad_lvl_o), .pend_nxt_o(pend_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE; beat_q <= '0; vpn_q <= '0; fault_o <= FLT_NONE;
      nx_q <= 1'b0; pk_q <= 1'b0; four_q <= 1'b0; spl_q <= 1'b0;
      fin_pfn_q <= '0; fin_pk_q <= '0; fin_d_q <= 1'b0; fin_mt_q <= '0; fin_sz_q <= '0;
      fill_valid_o <= 1'b0;
    end else begin
      fill_valid_o <= 1'b0;
      if (start_i) begin
        state_q <= ST_WALK; beat_q <= '0; fault_o <= FLT_NONE; vpn_q <= lin_vpn_i;
        nx_q <= nx_en_i; pk_q <= pk_en_i; four_q <= four_lvl_i; spl_q <= splinter_en_i;
        fin_pfn_q <= '0; fin_pk_q <= '0; fin_d_q <= 1'b0; fin_mt_q <= '0; fin_sz_q <= '0;
      end else begin
        case (state_q)
          ST_WALK: begin
            if (beat_bad) begin
              fault_o <= beat_flt;
              state_q <= ST_END;
            end else if (beat_ok) begin
              beat_q <= beat_q + LVL_W'(1);
              if (is_final) begin
                fin_pfn_q <= ent_data_i[PA_W-1:12];
                fin_pk_q  <= (four_q && pk_q) ? ent_data_i[B_PK+3:B_PK] : 4'd0;
                fin_d_q   <= ent_data_i[B_DRT];
                fin_mt_q  <= ent_data_i[B_MT+1:B_MT];
                fin_sz_q  <= size_now;
                if (pend_nxt == '0) begin
                  fill_valid_o <= 1'b1;
                  state_q <= ST_END;
                end else begin
                  state_q <= ST_WAIT;
                end
              end
            end
          end
          ST_WAIT: begin
            if (pend_nxt == '0) begin
              fill_valid_o <= 1'b1;
              state_q <= ST_END;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign fill_pfn_o   = build_pfn(fin_pfn_q, vpn_q, fin_sz_q, spl_q);
  assign fill_vpn_o   = build_vpn(vpn_q, fin_sz_q, spl_q);
  assign fill_pkey_o  = fin_pk_q;
  assign fill_dirty_o = fin_d_q;
  assign fill_mtype_o = fin_mt_q;
  assign fill_size_o  = fin_sz_q;

  assert_no_fill_on_fault_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid_o |-> (fault_o == FLT_NONE));
  assert_fault_code_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o != 2'b11);
  assert_fill_after_acks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid_o |-> !ad_req_o);
  assert_fault_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((fault_o != FLT_NONE) && !start_i) |=> $stable(fault_o));
  assert_size_legal_R11: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid_o |-> (fill_size_o != 2'b11));
  assert_fill_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid_o && !start_i) |=> !fill_valid_o);
endmodule

// File: tb/pwa_top_tb.sv
module pwa_top_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic start = 0, nx_en = 0, pk_en = 0, four = 0, spl = 0;
  logic [35:0] lvpn = '0;
  logic ev = 0, elast = 0, ack = 0;
  logic [63:0] ed = '0;
  logic fv, fw, fu, fnx, fd, areq;
  logic [35:0] fvpn;
  logic [27:0] fpfn;
  logic [3:0] fpk;
  logic [1:0] fmt, fsz, flt, alvl;

  int checks = 0, fails = 0;
  bit finished = 0;

  pwa_top dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .lin_vpn_i(lvpn), .nx_en_i(nx_en),
    .pk_en_i(pk_en), .four_lvl_i(four), .splinter_en_i(spl), .ent_valid_i(ev),
    .ent_data_i(ed), .ent_last_i(elast), .ad_ack_i(ack), .fill_valid_o(fv),
    .fill_vpn_o(fvpn), .fill_pfn_o(fpfn), .fill_write_o(fw), .fill_user_o(fu),
    .fill_nx_o(fnx), .fill_pkey_o(fpk), .fill_dirty_o(fd), .fill_mtype_o(fmt),
    .fill_size_o(fsz), .fault_o(flt), .ad_req_o(areq), .ad_lvl_o(alvl)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mk(input logic [27:0] pfn, input logic p, input logic w,
      input logic u, input logic a, input logic d, input logic ps, input logic [1:0] mt,
      input logic [3:0] pk, input logic x);
    logic [63:0] e = 64'd0;
    e[0] = p; e[1] = w; e[2] = u; e[4:3] = mt; e[5] = a; e[6] = d; e[7] = ps;
    e[39:12] = pfn; e[62:59] = pk; e[63] = x;
    return e;
  endfunction

  task automatic begin_walk(input logic [35:0] v, input logic nx, input logic pk,
      input logic f4, input logic sp);
    start = 1; lvpn = v; nx_en = nx; pk_en = pk; four = f4; spl = sp;
    @(negedge clk);
    start = 0;
  endtask

  task automatic beat(input logic [63:0] e, input logic last);
    ev = 1; ed = e; elast = last;
    @(negedge clk);
    ev = 0; elast = 0;
  endtask

  task automatic give_ack();
    ack = 1;
    @(negedge clk);
    ack = 0;
  endtask

  task automatic t_reset();
    check("R12 reset fill", fv, 0);
    check("R6 reset fault", flt, 0);
    check("R7 reset req", areq, 0);
  endtask

  task automatic t_4k_merge();
    begin_walk(36'h7F1234567, 1, 1, 1, 0);
    beat(mk(28'h1, 1, 1, 1, 1, 1, 0, 2'b11, 4'h9, 0), 0);
    beat(mk(28'h2, 1, 1, 1, 1, 0, 0, 2'b00, 4'h0, 1), 0);
    beat(mk(28'h3, 1, 0, 1, 1, 0, 0, 2'b00, 4'h0, 0), 0);
    beat(mk(28'hABCDE, 1, 1, 1, 1, 1, 0, 2'b10, 4'h5, 0), 1);
    check("R12 fill pulse 4k", fv, 1);
    check("R1 write AND", fw, 0);
    check("R2 user AND", fu, 1);
    check("R3 nx OR", fnx, 1);
    check("R4 pkey final", fpk, 4'h5);
    check("R5 dirty final", fd, 1);
    check("R5 mtype final", fmt, 2'b10);
    check("R11 size 4k", fsz, 0);
    check("R11 pfn 4k", fpfn, 28'hABCDE);
    check("R11 vpn 4k", fvpn, 36'h7F1234567);
    @(negedge clk);
    check("R12 fill one cycle", fv, 0);
  endtask

  task automatic t_gates();
    begin_walk(36'h1, 0, 1, 0, 0);
    beat(mk(28'h1, 1, 1, 0, 1, 0, 0, 2'b00, 4'h0, 1), 0);
    beat(mk(28'h2, 1, 1, 1, 1, 0, 0, 2'b00, 4'h0, 1), 0);
    beat(mk(28'h3, 1, 1, 1, 1, 0, 0, 2'b00, 4'h0, 1), 0);
    beat(mk(28'h4, 1, 1, 1, 1, 0, 0, 2'b01, 4'hF, 1), 1);
    check("R12 fill gates", fv, 1);
    check("R3 nx gated off", fnx, 0);
    check("R4 pkey gated off", fpk, 0);
    check("R2 user AND low", fu, 0);
    check("R1 write all set", fw, 1);
  endtask

  task automatic t_2m_splinter();
    logic [35:0] v = 36'h0_0402_35;
    begin_walk(v, 0, 0, 1, 1);
    beat(mk(28'h1, 1, 1, 1, 1, 1, 0, 2'b11, 4'h0, 0), 0);
    beat(mk(28'h2, 1, 1, 1, 1, 1, 0, 2'b11, 4'h0, 0), 0);
    beat(mk(28'h0ABCD200, 1, 1, 1, 1, 0, 1, 2'b01, 4'h0, 0), 0);
    check("R12 fill 2m", fv, 1);
    check("R8 pfn splinter", fpfn, {28'h0ABCD200 >> 9, v[8:0]});
    check("R8 vpn splinter", fvpn, v);
    check("R11 size 2m", fsz, 1);
    check("R5 dirty from big entry", fd, 0);
    check("R5 mtype from big entry", fmt, 2'b01);
  endtask

  task automatic t_1g_aligned();
    logic [35:0] v = 36'hF_1234_5678 & 36'hF_FFFF_FFFF;
    logic [27:0] raw = 28'h0AC5_1234;
    begin_walk(v, 0, 0, 1, 0);
    beat(mk(28'h1, 1, 1, 1, 1, 0, 0, 2'b00, 4'h0, 0), 0);
    beat(mk(raw, 1, 1, 1, 1, 1, 1, 2'b11, 4'h0, 0), 0);
    check("R12 fill 1g", fv, 1);
    check("R11 size 1g", fsz, 2);
    check("R11 pfn aligned", fpfn, {raw[27:18], 18'd0});
    check("R11 vpn aligned", fvpn, {v[35:18], 18'd0});
  endtask

  task automatic t_faults();
    begin_walk(36'h5, 0, 0, 1, 0);
    beat(mk(28'h1, 1, 1, 1, 1, 0, 0, 2'b00, 4'h0, 0), 0);
    beat(mk(28'h2, 0, 1, 1, 1, 0, 0, 2'b00, 4'h0, 0), 0);
    check("R6 not present", flt, 2'b01);
    check("R6 no fill on fault", fv, 0);
    beat(mk(28'h3, 1, 1, 1, 1, 0, 0, 2'b00, 4'h0, 0), 0);
    beat(mk(28'h4, 1, 1, 1, 1, 0, 0, 2'b00, 4'h0, 0), 1);
    check("R9 beats ignored no fill", fv, 0);
    check("R9 fault held", flt, 2'b01);
    begin_walk(36'h6, 0, 0, 1, 0);
    check("R10 start clears fault", flt, 0);
    beat(mk(28'h1, 1, 1, 1, 1, 0, 0, 2'b00, 4'h0, 0) | (64'd1 << 45), 0);
    check("R6 reserved", flt, 2'b10);
    begin_walk(36'h7, 0, 0, 1, 0);
    beat(mk(28'h1, 0, 1, 1, 1, 0, 0, 2'b00, 4'h0, 0) | (64'd1 << 51), 0);
    check("R6 not-present priority", flt, 2'b01);
    begin_walk(36'h8, 0, 0, 1, 0);
    beat(mk(28'h1, 1, 1, 1, 0, 0, 0, 2'b00, 4'h0, 0), 0);
    check("R7 req before fault", areq, 1);
    beat(mk(28'h2, 1, 1, 1, 1, 0, 0, 2'b00, 4'h0, 0) | (64'd1 << 40), 0);
    check("R6 fault drops request", areq, 0);
  endtask

  task automatic t_accessed();
    begin_walk(36'h9, 0, 0, 1, 0);
    beat(mk(28'h1, 1, 1, 1, 0, 0, 0, 2'b00, 4'h0, 0), 0);
    check("R7 req raised", areq, 1);
    check("R7 req level 0", alvl, 0);
    beat(mk(28'h2, 1, 1, 1, 1, 0, 0, 2'b00, 4'h0, 0), 0);
    beat(mk(28'h3, 1, 1, 1, 0, 0, 0, 2'b00, 4'h0, 0), 0);
    beat(mk(28'h44, 1, 1, 1, 1, 0, 0, 2'b00, 4'h0, 0), 1);
    check("R7 fill held", fv, 0);
    check("R7 lowest level first", alvl, 0);
    give_ack();
    check("R7 next level", alvl, 2);
    check("R7 still held", fv, 0);
    give_ack();
    check("R12 fill after last ack", fv, 1);
    check("R7 req cleared", areq, 0);
    check("R7 pfn after acks", fpfn, 28'h44);
  endtask

  task automatic t_restart();
    begin_walk(36'hA, 1, 0, 1, 0);
    beat(mk(28'h1, 1, 0, 0, 0, 0, 0, 2'b00, 4'h0, 1), 0);
    begin_walk(36'hB, 1, 0, 1, 0);
    check("R10 request cleared", areq, 0);
    beat(mk(28'h1, 1, 1, 1, 1, 0, 0, 2'b00, 4'h0, 0), 0);
    beat(mk(28'h2, 1, 1, 1, 1, 0, 0, 2'b00, 4'h0, 0), 0);
    beat(mk(28'h3, 1, 1, 1, 1, 0, 0, 2'b00, 4'h0, 0), 0);
    beat(mk(28'h77, 1, 1, 1, 1, 0, 0, 2'b00, 4'h0, 0), 0);
    check("R5 bottom level is final", fv, 1);
    check("R10 write not leaked", fw, 1);
    check("R10 user not leaked", fu, 1);
    check("R10 nx not leaked", fnx, 0);
  endtask

  initial begin
    #200_0000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_4k_merge();
    t_gates();
    t_2m_splinter();
    t_1g_aligned();
    t_faults();
    t_accessed();
    t_restart();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule